// File: doc/BRIEF.md
# Base-Limit Access Window Guard

This block sits beside a processor's memory port and decides, access by access, whether the address is allowed. Two registers describe one window: a base, which is the lowest legal address, and a limit, which is the number of legal addresses above it. While the processor runs in user mode, an access is allowed only if `base <= addr < base + limit`. An access outside that window is stopped at the port and raises a fault in the same cycle, so the operating system can take over. In supervisor mode every address is allowed.

The window registers are loaded through a separate write port. Each write carries the privilege level of the code that issued it. A write issued from supervisor code is accepted. A write issued from user code is refused, leaves the register as it was, and raises the same fault output with its own cause bit. Both registers reset to zero, so user code cannot reach memory until supervisor code has set up a window.

Top module: `bl_guard`

## Requirements
- R1: After reset, base and limit are both 0, so every user-mode access faults and a supervisor-mode access passes.
- R2: A valid user-mode access with `base <= addr < base + limit` drives `acc_en_o` high and `fault_o` low.
- R3: A valid user-mode access outside the window drives `acc_en_o` low and `fault_o` high in the same cycle, with bit 0 of `fault_cause_o` set.
- R4: The sum `base + limit` is formed one bit wider than an address, so a window that runs past the top of the address space grants no address below base.
- R5: A valid supervisor-mode access (`user_mode_i` = 0) passes for any address, base and limit.
- R6: A register write with `reg_we_i` high and `reg_user_i` low loads `reg_data_i` into base when `reg_sel_i` = 0, or into limit when `reg_sel_i` = 1. The new value governs accesses from the next cycle on.
- R7: A register write with `reg_user_i` high leaves both registers unchanged and drives `fault_o` high in that cycle, with bit 1 of `fault_cause_o` set.
- R8: `mem_we_o` equals `acc_we_i` for an access that is granted, and is 0 whenever the access is blocked.
- R9: With no valid access and no register write, `fault_o`, `acc_en_o` and `mem_we_o` are 0.
- R10: A blocked access and a refused register write in the same cycle raise `fault_o` once, with both cause bits set. The access is judged against the register values from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A memory access is presented this cycle |
| acc_addr_i | input | AW | Address of the access |
| acc_we_i | input | 1 | The access is a write |
| user_mode_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| reg_we_i | input | 1 | Request to write a window register |
| reg_sel_i | input | 1 | Register select: 0 = base, 1 = limit |
| reg_user_i | input | 1 | Privilege of the register write: 1 = user |
| reg_data_i | input | AW | Value to write |
| acc_en_o | output | 1 | The access is granted to memory |
| mem_we_o | output | 1 | Memory write enable after gating |
| fault_o | output | 1 | Protection fault, valid in the offending cycle |
| fault_cause_o | output | 2 | Bit 0 = access out of window, bit 1 = refused register write |

## Verification
A range check and a register write can happen in the same cycle. Two outcomes follow from that. First, a refused user write can coincide with a blocked access. Second, a supervisor write that changes the window can coincide with an access that is still judged against the old window. The bench forces both cases by driving an access and a register write together. It checks that the access result follows the old bounds and that the cause bits combine. It then checks an access on the next cycle to confirm whether the register changed.

// File: rtl/bl_guard_pkg.sv
package bl_guard_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;

  localparam int unsigned CAUSE_W     = 2;
  localparam int unsigned CAUSE_RANGE = 0;
  localparam int unsigned CAUSE_PRIV  = 1;
endpackage

// File: rtl/bl_bound_regs.sv
module bl_bound_regs
  import bl_guard_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic          user_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] limit_o,
  output logic          refused_o
);
  logic [AW-1:0] base_q, limit_q;
  logic          accept;

  assign accept    = we_i && !user_i;
  assign refused_o = we_i && user_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (accept) begin
      if (reg_sel_e'(sel_i) == SEL_BASE) base_q  <= data_i;
      else                               limit_q <= data_i;
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;

  assert_refused_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && user_i) |=> ($stable(base_q) && $stable(limit_q)));

  assert_load_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !user_i && !sel_i) |=> (base_q == $past(data_i)) && $stable(limit_q));
endmodule

// File: rtl/bl_window_cmp.sv
module bl_window_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic          inside_o
);
  localparam int unsigned EW = AW + 1;  // carry bit keeps the top end from wrapping

  logic [EW-1:0] lo, hi, a;

  assign a        = {1'b0, addr_i};
  assign lo       = {1'b0, base_i};
  assign hi       = lo + {1'b0, limit_i};
  assign inside_o = (a >= lo) && (a < hi);
endmodule

// File: rtl/bl_guard.sv
module bl_guard
  import bl_guard_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [AW-1:0]      acc_addr_i,
  input  logic               acc_we_i,
  input  logic               user_mode_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic               reg_user_i,
  input  logic [AW-1:0]      reg_data_i,
  output logic               acc_en_o,
  output logic               mem_we_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o
);
  logic [AW-1:0] base_w, limit_w;
  logic          inside_w, refused_w, range_fault;

  bl_bound_regs #(.AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .user_i    (reg_user_i),
    .data_i    (reg_data_i),
    .base_o    (base_w),
    .limit_o   (limit_w),
    .refused_o (refused_w)
  );

  bl_window_cmp #(.AW(AW)) u_cmp (
    .addr_i   (acc_addr_i),
    .base_i   (base_w),
    .limit_i  (limit_w),
    .inside_o (inside_w)
  );

  assign range_fault = acc_valid_i && user_mode_i && !inside_w;

  always_comb begin
    fault_cause_o              = '0;
    fault_cause_o[CAUSE_RANGE] = range_fault;
    fault_cause_o[CAUSE_PRIV]  = refused_w;
  end

  assign fault_o  = |fault_cause_o;
  assign acc_en_o = acc_valid_i && !range_fault;
  assign mem_we_o = acc_en_o && acc_we_i;

  assert_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (acc_en_o && !fault_cause_o[CAUSE_RANGE]));

  assert_sup_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !user_mode_i) |-> acc_en_o);

  assert_grant_low_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_o && user_mode_i) |-> (acc_addr_i >= base_w));

  assert_range_fault_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_cause_o[CAUSE_RANGE] |-> (acc_valid_i && user_mode_i && !acc_en_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !reg_we_i) |-> (!fault_o && !acc_en_o && !mem_we_o));

  assert_zero_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_w == '0 && acc_valid_i && user_mode_i) |-> fault_o);
endmodule

// File: tb/bl_guard_test.sv
module bl_guard_test;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          acc_valid = 0, acc_we = 0, user_mode = 0;
  logic [AW-1:0] acc_addr = '0, reg_data = '0;
  logic          reg_we = 0, reg_sel = 0, reg_user = 0;
  logic          acc_en, mem_we, fault;
  logic [1:0]    cause;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  bl_guard #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_we_i(acc_we),
    .user_mode_i(user_mode), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_user_i(reg_user), .reg_data_i(reg_data),
    .acc_en_o(acc_en), .mem_we_o(mem_we), .fault_o(fault), .fault_cause_o(cause)
  );

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got en/we/fault/cause=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] model(int b, int l, int a, bit v, bit u, bit w, bit refused);
    bit in_win = (a >= b) && (a < b + l);
    bit rf = v && u && !in_win;
    bit en = v && !rf;
    return {en, en && w, rf || refused, refused, rf};
  endfunction

  task automatic idle_drive();
    acc_valid = 0; acc_we = 0; reg_we = 0; reg_user = 0;
  endtask

  task automatic wr(bit sel, int val);
    @(negedge clk);
    idle_drive();
    reg_we = 1; reg_sel = sel; reg_user = 0; reg_data = AW'(val);
    @(negedge clk);
    idle_drive();
  endtask

  task automatic access(int a, bit u, bit w);
    @(negedge clk);
    acc_valid = 1; acc_addr = AW'(a); user_mode = u; acc_we = w;
    #2;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R9 idle, R1 reset window empty
    @(negedge clk); #2;
    chk("R9", {acc_en, mem_we, fault, cause}, 5'b00000);
    for (int a = 0; a < N; a++) begin
      access(a, 1, 1);
      chk("R1", {acc_en, mem_we, fault, cause}, model(0, 0, a, 1, 1, 1, 0));
      access(a, 0, 1);
      chk("R1", {acc_en, mem_we, fault, cause}, 5'b11000);
    end
    // exhaustive windows: R2 R3 R4 R5 R6 R8
    for (int b = 0; b < N; b++) begin
      for (int l = 0; l < N; l++) begin
        wr(0, b);
        wr(1, l);
        for (int a = 0; a < N; a++) begin
          for (int m = 0; m < 4; m++) begin
            bit u = m[0];
            bit w = m[1];
            access(a, u, w);
            if (!u)
              chk("R5", {acc_en, mem_we, fault, cause}, model(b, l, a, 1, 0, w, 0));
            else if (b + l > N && a < b)
              chk("R4", {acc_en, mem_we, fault, cause}, model(b, l, a, 1, 1, w, 0));
            else if ((a >= b) && (a < b + l))
              chk("R2_R8", {acc_en, mem_we, fault, cause}, model(b, l, a, 1, 1, w, 0));
            else
              chk("R3_R8", {acc_en, mem_we, fault, cause}, model(b, l, a, 1, 1, w, 0));
          end
        end
      end
    end
    // window now base=15 limit=15; set base=4 limit=4
    wr(0, 4);
    wr(1, 4);
    // R10: refused user write to base=0 together with a blocked access
    @(negedge clk);
    acc_valid = 1; acc_addr = 4'd1; user_mode = 1; acc_we = 1;
    reg_we = 1; reg_sel = 0; reg_user = 1; reg_data = 4'd0;
    #2;
    chk("R10", {acc_en, mem_we, fault, cause}, 5'b00111);
    // R7: base stays 4, so addr 1 still faults, addr 4 passes
    access(1, 1, 0);
    reg_we = 0;
    #1;
    chk("R7", {acc_en, mem_we, fault, cause}, 5'b00101);
    access(4, 1, 0);
    chk("R7", {acc_en, mem_we, fault, cause}, 5'b10000);
    // refused limit write alone (no access)
    @(negedge clk);
    idle_drive();
    reg_we = 1; reg_sel = 1; reg_user = 1; reg_data = 4'd15;
    #2;
    chk("R7", {acc_en, mem_we, fault, cause}, 5'b00110);
    access(9, 1, 1);
    reg_we = 0;
    #1;
    chk("R7", {acc_en, mem_we, fault, cause}, 5'b00101);
    // R10: supervisor write of base=0 in the same cycle; access sees old base 4
    @(negedge clk);
    acc_valid = 1; acc_addr = 4'd2; user_mode = 1; acc_we = 1;
    reg_we = 1; reg_sel = 0; reg_user = 0; reg_data = 4'd0;
    #2;
    chk("R10", {acc_en, mem_we, fault, cause}, 5'b00101);
    access(2, 1, 1);
    reg_we = 0;
    #1;
    chk("R6", {acc_en, mem_we, fault, cause}, 5'b11000);
    @(negedge clk);
    idle_drive();
    #2;
    chk("R9", {acc_en, mem_we, fault, cause}, 5'b00000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule